// File: doc/BRIEF.md
# Interleave Gap Insertion Denormalizer

This block turns a normalized memory address back into a system address for a memory layout where the interleave selector bits are split. It first opens zero-filled gaps in the address where the selector bits belong. Channel bits take positions 8 to 11. Die bits start at bit 12. A fifth channel bit, when present, goes to bit 14.

It then derives a 7-bit station identifier from the station fabric ID, relative to a base destination fabric ID. In that identifier the stack bit is moved to the most significant position. The identifier is shifted to the interleave start position and ORed into the gapped address.

The result is registered and appears one clock after the request, together with an error flag. Any configuration that cannot be translated produces the error flag and an all-ones address.

Top module: `ilv_gap_denorm`

## Requirements
- R1: `res_valid` rises exactly one clock after a cycle with `req_valid` high and is low otherwise; a synchronous reset clears `res_valid`, `res_err` and `res_addr`.
- R2: If `ilv_start` is not 8, the result has `res_err` = 1 and `res_addr` all ones.
- R3: If `chan_cnt` is not 8, 16 or 32 (encoded as the plain count), or `die_cnt` is not 1, 2 or 4 (plain count), the result has `res_err` = 1 and `res_addr` all ones.
- R4: On a valid translation, result bits 7:0 equal normalized address bits 7:0.
- R5: A gap of min(log2(chan_cnt), 4) zero bits opens at bit 8; normalized bits from 8 upward move up by that width.
- R6: After the channel gap, a gap of log2(die_cnt) bits opens at bit 12; with one die no die gap exists.
- R7: With 32 channels, one more gap bit opens at bit 14 after the die gap.
- R8: The adjusted ID is `st_fid` minus `base_fid`, modulo 2^FID_W, and is formed before any field is taken from it.
- R9: The die ID is (adjusted ID AND `die_mask`) shifted right by `die_shift`; its two low bits are used.
- R10: The 7-bit station ID is {adjusted bit 4, die ID bits 1:0, adjusted bits 3:0}, MSB first; it is shifted left by 8 and ORed into the gapped address.
- R11: The datapath is OUT_W = 52 bits wide; bits pushed above bit 51 are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| norm_addr | input | ADDR_W (48) | Normalized address |
| chan_cnt | input | 6 | Interleaved channel count |
| die_cnt | input | 3 | Interleaved die count |
| ilv_start | input | 6 | Interleave start bit position |
| st_fid | input | FID_W (12) | Station fabric ID |
| base_fid | input | FID_W (12) | Base destination fabric ID |
| die_mask | input | FID_W (12) | Die ID mask |
| die_shift | input | 4 | Die ID shift |
| res_valid | output | 1 | Result strobe |
| res_err | output | 1 | Translation error |
| res_addr | output | OUT_W (52) | Denormalized address |

## Verification
The bench builds the block with its default parameters. With a 48-bit input and a 52-bit datapath, the widest case opens seven gaps in an all-ones input, which carries the top three normalized bits past bit 51; this makes the discard rule of R11 observable. A 12-bit fabric ID lets a station ID below the base wrap around, and random die masks and shifts reach every die field placement.

// File: rtl/ilv_gap_denorm.sv
module ilv_gap_denorm #(
  parameter int ADDR_W  = 48,
  parameter int OUT_W   = 52,
  parameter int FID_W   = 12,
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  norm_addr,
  input  logic [5:0]         chan_cnt,
  input  logic [2:0]         die_cnt,
  input  logic [5:0]         ilv_start,
  input  logic [FID_W-1:0]   st_fid,
  input  logic [FID_W-1:0]   base_fid,
  input  logic [FID_W-1:0]   die_mask,
  input  logic [SHIFT_W-1:0] die_shift,
  output logic               res_valid,
  output logic               res_err,
  output logic [OUT_W-1:0]   res_addr
);
  localparam int CH_POS  = 8;
  localparam int DIE_POS = 12;
  localparam int XCH_POS = 14;
  localparam int ST_W    = 7;

  function automatic logic [OUT_W-1:0] open_gap(input logic [OUT_W-1:0] x,
                                                input int pos, input int width);
    logic [OUT_W-1:0] keep;
    keep = (OUT_W'(1) << pos) - OUT_W'(1);
    return ((x & ~keep) << width) | (x & keep);
  endfunction

  logic       chan_ok, die_ok, bad;
  int         ch_bits, die_bits, ch_lo;
  logic [OUT_W-1:0] g_ch, g_die, g_all, merged;
  logic [FID_W-1:0] adj, die_id;
  logic [ST_W-1:0]  station;

  always_comb begin
    chan_ok = 1'b1;
    case (chan_cnt)
      6'd8:    ch_bits = 3;
      6'd16:   ch_bits = 4;
      6'd32:   ch_bits = 5;
      default: begin ch_bits = 0; chan_ok = 1'b0; end
    endcase
    die_ok = 1'b1;
    case (die_cnt)
      3'd1:    die_bits = 0;
      3'd2:    die_bits = 1;
      3'd4:    die_bits = 2;
      default: begin die_bits = 0; die_ok = 1'b0; end
    endcase
    ch_lo = (ch_bits > 4) ? 4 : ch_bits;
  end

  assign bad   = !(chan_ok && die_ok && (ilv_start == 6'(CH_POS)));
  assign g_ch  = open_gap(OUT_W'(norm_addr), CH_POS, ch_lo);
  assign g_die = open_gap(g_ch, DIE_POS, die_bits);
  assign g_all = (ch_bits > 4) ? open_gap(g_die, XCH_POS, 1) : g_die;

  assign adj     = st_fid - base_fid;
  assign die_id  = (adj & die_mask) >> die_shift;
  assign station = {adj[4], die_id[1:0], adj[3:0]};
  assign merged  = g_all | (OUT_W'(station) << CH_POS);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      res_addr  <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_err  <= bad;
        res_addr <= bad ? '1 : merged;
      end
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid);
  a_r2_bad_start: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ilv_start != 6'(CH_POS)) |=> (res_err && &res_addr));
  a_r3_err_ones: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_err) |-> &res_addr);
  a_r4_low_pass: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !bad) |=> (res_addr[CH_POS-1:0] == $past(norm_addr[CH_POS-1:0])));
endmodule

// File: tb/test_ilv_gap_denorm.sv
`timescale 1ns/1ps
module test_ilv_gap_denorm;
  localparam int ADDR_W = 48;
  localparam int OUT_W  = 52;
  localparam int FID_W  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] norm_addr = '0;
  logic [5:0] chan_cnt = 6'd8;
  logic [2:0] die_cnt = 3'd1;
  logic [5:0] ilv_start = 6'd8;
  logic [FID_W-1:0] st_fid = '0, base_fid = '0, die_mask = '0;
  logic [3:0] die_shift = '0;
  logic res_valid, res_err;
  logic [OUT_W-1:0] res_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ilv_gap_denorm i_ilv_gap_denorm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .norm_addr(norm_addr),
    .chan_cnt(chan_cnt), .die_cnt(die_cnt), .ilv_start(ilv_start),
    .st_fid(st_fid), .base_fid(base_fid), .die_mask(die_mask),
    .die_shift(die_shift), .res_valid(res_valid), .res_err(res_err),
    .res_addr(res_addr));

  // Bit-by-bit reference: walk the output, skip gap positions, fill the rest in order.
  function automatic logic [OUT_W:0] model(input logic [ADDR_W-1:0] a, input int ch,
      input int dc, input int st, input logic [FID_W-1:0] sf, input logic [FID_W-1:0] bf,
      input logic [FID_W-1:0] dm, input int ds);
    logic [OUT_W-1:0] r;
    logic [FID_W-1:0] rel, did;
    logic [6:0] sid;
    int cb, db, src;
    bit gap;
    cb = (ch == 8) ? 3 : (ch == 16) ? 4 : (ch == 32) ? 5 : -1;
    db = (dc == 1) ? 0 : (dc == 2) ? 1 : (dc == 4) ? 2 : -1;
    if (cb < 0 || db < 0 || st != 8) return {1'b1, {OUT_W{1'b1}}};
    r = '0;
    src = 0;
    for (int p = 0; p < OUT_W; p++) begin
      gap = (p >= 8 && p < 8 + ((cb > 4) ? 4 : cb)) || (p >= 12 && p < 12 + db)
            || (cb == 5 && p == 14);
      if (!gap) begin
        r[p] = (src < ADDR_W) ? a[src] : 1'b0;
        src++;
      end
    end
    rel = sf + (~bf + 1'b1);
    did = (rel & dm) >> ds;
    sid = {rel[4], did[1:0], rel[3:0]};
    for (int k = 0; k < 7; k++) if (sid[k]) r[8 + k] = 1'b1;
    return {1'b0, r};
  endfunction

  task automatic check(input string tag, input logic [OUT_W:0] got, input logic [OUT_W:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got err=%0b addr=%h, expected err=%0b addr=%h",
               tag, got[OUT_W], got[OUT_W-1:0], exp[OUT_W], exp[OUT_W-1:0]);
    end
  endtask

  task automatic run(input string tag, input logic [ADDR_W-1:0] a, input int ch, input int dc,
      input int st, input logic [FID_W-1:0] sf, input logic [FID_W-1:0] bf,
      input logic [FID_W-1:0] dm, input int ds);
    @(negedge clk);
    req_valid = 1'b1; norm_addr = a; chan_cnt = 6'(ch); die_cnt = 3'(dc);
    ilv_start = 6'(st); st_fid = sf; base_fid = bf; die_mask = dm; die_shift = 4'(ds);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R1 valid"}, {52'd0, res_valid}, {52'd0, 1'b1});
    check(tag, {res_err, res_addr}, model(a, ch, dc, st, sf, bf, dm, ds));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    logic [ADDR_W-1:0] ones;
    ones = '1;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset", {res_err, res_addr}, '0);
    check("R1 reset valid", {52'd0, res_valid}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle", {52'd0, res_valid}, '0);

    run("R2 start7", 48'h1234, 16, 2, 7, 12'h5, 12'h0, 12'h60, 5);
    run("R2 start9", 48'h1234, 32, 4, 9, 12'h5, 12'h0, 12'h60, 5);
    run("R3 chan12", 48'h1234, 12, 1, 8, 12'h5, 12'h0, 12'h60, 5);
    run("R3 die3",   48'h1234, 8, 3, 8, 12'h5, 12'h0, 12'h60, 5);
    run("R4 R5 8ch", ones, 8, 1, 8, 12'h0, 12'h0, 12'h0, 0);
    run("R5 R6 16ch2die", ones, 16, 2, 8, 12'h0, 12'h0, 12'h0, 0);
    run("R6 R7 32ch1die", ones, 32, 1, 8, 12'h0, 12'h0, 12'h0, 0);
    run("R7 R11 32ch4die", ones, 32, 4, 8, 12'h0, 12'h0, 12'h0, 0);
    run("R8 wrap", 48'h0, 32, 4, 8, 12'h003, 12'h010, 12'h060, 5);
    run("R9 R10 fields", 48'h0, 32, 4, 8, 12'h07f, 12'h000, 12'h060, 5);
    run("R10 stack only", 48'h0, 32, 1, 8, 12'h010, 12'h000, 12'h000, 0);
    run("R9 shift0", 48'habc, 16, 4, 8, 12'h2a3, 12'h200, 12'h003, 0);

    @(negedge clk);
    check("R1 no repeat", {52'd0, res_valid}, '0);

    for (int n = 0; n < 400; n++) begin
      int chs[3] = '{8, 16, 32};
      int dcs[3] = '{1, 2, 4};
      int ch, dc, st;
      ch = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 63)) : chs[$urandom_range(0, 2)];
      dc = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 7)) : dcs[$urandom_range(0, 2)];
      st = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 63)) : 8;
      run("R4 R5 R6 R7 R8 R9 R10 R11 random", {16'($urandom), $urandom}, ch, dc, st,
          12'($urandom), 12'($urandom), 12'($urandom), int'($urandom_range(0, 15)));
    end

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset again", {res_err, res_addr}, '0);
    finish_run();
  end
endmodule